// File: doc/BRIEF.md
# Keyboard Controller Register Interface

This block gives a processor two byte-wide register ports for a legacy-style keyboard controller. One address returns a status byte when read and takes a command byte when written. The other address returns the pending scancode or reply byte when read and takes command arguments when written. On the keyboard side, already-decoded scancodes arrive as a byte with a valid strobe, and a small LED register drives the keyboard indicator lamps.

Software polls the status byte until its output-buffer-full bit is 1, then reads the data port. It runs a self test, enables the keyboard and sets the LEDs with command bytes. After the set-LED command, the next data-port write is taken as the LED state and is answered with an acknowledge byte. Only one byte is held for the host. A scancode that cannot be stored is lost and raises a timeout flag.

Top module: `kbd_regs`

## Requirements
- R1: After reset the status byte reads 0x00, the LED output is 0 and the keyboard is disabled.
- R2: A read of the command port (0x64) returns the status byte in the same cycle. The layout is: bit 0 output-buffer-full, bit 1 input-buffer-full, bit 2 system flag, bit 3 last host write went to the command port, bit 6 timeout. Bits 7, 5 and 4 read 0.
- R3: A read of the data port (0x60) returns the held byte in the same cycle. Output-buffer-full reads 0 from the next cycle, unless a new byte is stored on that edge.
- R4: Input-buffer-full reads 1 in the cycle after any host write to either port and reads 0 in the cycle after a cycle with no such write.
- R5: Command 0xAA makes the next cycle hold 0x55 in the output buffer, with output-buffer-full and the system flag set.
- R6: Scancodes are ignored while the keyboard is disabled. Command 0xAE enables the keyboard.
- R7: After command 0xED, the next data-port write sets the LED output to write-data bits 2:0 and places 0xFA in the output buffer. A data-port write with no 0xED pending changes neither the LEDs nor the output buffer.
- R8: With the keyboard enabled and the output buffer empty, a valid scancode is held in the output buffer, with output-buffer-full set, from the next cycle.
- R9: A scancode that arrives while the output buffer is full, or in the same cycle as a reply byte, is dropped and sets the timeout bit. A status read clears the timeout bit from the next cycle, unless a drop occurs in that cycle.
- R10: A reply byte (0x55 or 0xFA) replaces any unread byte. A command byte other than 0xED cancels a pending LED write. Unknown command bytes have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Port address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| key_valid | input | 1 | Scancode strobe |
| key_code | input | 8 | Decoded scancode |
| led_out | output | 3 | LED state |

## Verification
Read data is combinational, so a read returns the value of the state registers in the same cycle. Every side effect of a read, write or scancode (buffer flags, timeout, LED state, reply byte) becomes visible exactly one clock edge later. The bench drives each stimulus just after a falling edge and compares the read data and LED output two nanoseconds later, before the next rising edge. Its reference model advances on the same rising edge as the design, so each side effect is checked in the first cycle it is due.

// File: rtl/kbd_regs.sv
module kbd_regs #(
  parameter logic [7:0] DATA_PORT    = 8'h60,
  parameter logic [7:0] CMD_PORT     = 8'h64,
  parameter logic [7:0] CMD_SELFTEST = 8'hAA,
  parameter logic [7:0] CMD_ENABLE   = 8'hAE,
  parameter logic [7:0] CMD_SETLED   = 8'hED,
  parameter logic [7:0] SELFTEST_OK  = 8'h55,
  parameter logic [7:0] ACK_BYTE     = 8'hFA,
  parameter int         LED_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             key_valid,
  input  logic [7:0]       key_code,
  output logic [LED_W-1:0] led_out
);

  logic [7:0] obuf;
  logic       obf, ibf, tmo, sys_flag, last_cmd, kbd_en, led_pend;

  wire hit_data = (bus_addr == DATA_PORT);
  wire hit_cmd  = (bus_addr == CMD_PORT);
  wire wr_cmd   = bus_wr & hit_cmd;
  wire wr_data  = bus_wr & hit_data;
  wire rd_data  = bus_rd & ~bus_wr & hit_data;
  wire rd_stat  = bus_rd & ~bus_wr & hit_cmd;

  wire do_test  = wr_cmd & (bus_wdata == CMD_SELFTEST);
  wire do_led   = wr_data & led_pend;
  wire reply    = do_test | do_led;
  wire key_take = key_valid & kbd_en;
  wire key_drop = key_take & (obf | reply);

  wire [7:0] status = {1'b0, tmo, 2'b00, last_cmd, sys_flag, ibf, obf};

  assign bus_rdata = rd_stat ? status : (rd_data ? obuf : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0;
      obf  <= 1'b0;
    end else if (reply) begin
      obuf <= do_test ? SELFTEST_OK : ACK_BYTE;
      obf  <= 1'b1;
    end else if (key_take && !obf) begin
      obuf <= key_code;
      obf  <= 1'b1;
    end else if (rd_data) begin
      obf  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf      <= 1'b0;
      tmo      <= 1'b0;
      sys_flag <= 1'b0;
      last_cmd <= 1'b0;
      kbd_en   <= 1'b0;
      led_pend <= 1'b0;
      led_out  <= '0;
    end else begin
      ibf <= wr_cmd | wr_data;
      if (key_drop)     tmo <= 1'b1;
      else if (rd_stat) tmo <= 1'b0;
      if (do_test) sys_flag <= 1'b1;
      if (wr_cmd)       last_cmd <= 1'b1;
      else if (wr_data) last_cmd <= 1'b0;
      if (wr_cmd && bus_wdata == CMD_ENABLE) kbd_en <= 1'b1;
      if (wr_cmd)       led_pend <= (bus_wdata == CMD_SETLED);
      else if (wr_data) led_pend <= 1'b0;
      if (do_led) led_out <= bus_wdata[LED_W-1:0];
    end
  end

endmodule

// File: rtl/kbd_regs_chk.sv
module kbd_regs_chk #(
  parameter logic [7:0] DATA_PORT    = 8'h60,
  parameter logic [7:0] CMD_PORT     = 8'h64,
  parameter logic [7:0] CMD_SELFTEST = 8'hAA,
  parameter logic [7:0] SELFTEST_OK  = 8'h55,
  parameter logic [7:0] ACK_BYTE     = 8'hFA,
  parameter int         LED_W        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic             key_valid,
  input logic [LED_W-1:0] led_out,
  input logic [7:0]       obuf,
  input logic             obf,
  input logic             ibf,
  input logic             tmo,
  input logic             sys_flag,
  input logic             kbd_en,
  input logic             led_pend
);

  AST_IBF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == DATA_PORT || bus_addr == CMD_PORT) |=> ibf); // R4
  AST_IBF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !ibf); // R4
  AST_SELFTEST_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == CMD_PORT && bus_wdata == CMD_SELFTEST
    |=> obf && obuf == SELFTEST_OK && sys_flag); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == DATA_PORT && !(key_valid && kbd_en && !obf)
    |=> !obf); // R3
  AST_DISABLED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !kbd_en && !bus_wr && !bus_rd |=> $stable(obuf) && $stable(obf)); // R6
  AST_DROP_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && kbd_en && obf && !bus_wr |=> tmo && $stable(obuf)); // R9
  AST_LED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    led_pend && bus_wr && bus_addr == DATA_PORT
    |=> led_out == $past(bus_wdata[LED_W-1:0]) && obf && obuf == ACK_BYTE); // R7

endmodule

bind kbd_regs kbd_regs_chk #(
  .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT), .CMD_SELFTEST(CMD_SELFTEST),
  .SELFTEST_OK(SELFTEST_OK), .ACK_BYTE(ACK_BYTE), .LED_W(LED_W)
) i_kbd_regs_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .key_valid(key_valid), .led_out(led_out), .obuf(obuf),
  .obf(obf), .ibf(ibf), .tmo(tmo), .sys_flag(sys_flag), .kbd_en(kbd_en),
  .led_pend(led_pend)
);

// File: tb/test_kbd_regs.sv
module test_kbd_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       key_valid = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic [2:0] led_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbd_regs i_kbd_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_valid(key_valid),
    .key_code(key_code), .led_out(led_out)
  );

  // reference model state
  int m_obuf, m_obf, m_ibf, m_to, m_sys, m_lc, m_en, m_pend, m_led;
  int q_reply, q_byte, q_take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_obuf = 0; m_obf = 0; m_ibf = 0; m_to = 0; m_sys = 0;
      m_lc = 0; m_en = 0; m_pend = 0; m_led = 0;
    end else begin
      q_reply = 0; q_byte = 0;
      q_take = key_valid && m_en;
      if (bus_wr && bus_addr == 8'h64 && bus_wdata == 8'hAA) begin q_reply = 1; q_byte = 8'h55; end
      if (bus_wr && bus_addr == 8'h60 && m_pend != 0) begin q_reply = 1; q_byte = 8'hFA; end
      if (q_take && (m_obf != 0 || q_reply != 0)) m_to = 1;
      else if (bus_rd && !bus_wr && bus_addr == 8'h64) m_to = 0;
      if (bus_wr && bus_addr == 8'h60 && m_pend != 0) m_led = bus_wdata & 7;
      if (q_reply != 0) begin m_obuf = q_byte; m_obf = 1; end
      else if (q_take && m_obf == 0) begin m_obuf = key_code; m_obf = 1; end
      else if (bus_rd && !bus_wr && bus_addr == 8'h60) m_obf = 0;
      m_ibf = (bus_wr && (bus_addr == 8'h60 || bus_addr == 8'h64)) ? 1 : 0;
      if (bus_wr && bus_addr == 8'h64) begin
        m_lc = 1;
        if (bus_wdata == 8'hAA) m_sys = 1;
        if (bus_wdata == 8'hAE) m_en = 1;
        m_pend = (bus_wdata == 8'hED) ? 1 : 0;
      end else if (bus_wr && bus_addr == 8'h60) begin
        m_lc = 0;
        m_pend = 0;
      end
    end
  end

  function automatic int exp_status();
    return (m_to << 6) | (m_lc << 3) | (m_sys << 2) | (m_ibf << 1) | m_obf;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                      input logic [7:0] wd, input logic kv, input logic [7:0] kc,
                      input string tag);
    int e;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    key_valid = kv; key_code = kc;
    #2;
    e = 0;
    if (rd && !wr && a == 8'h64) e = exp_status();
    if (rd && !wr && a == 8'h60) e = m_obuf;
    check(tag, bus_rdata, e);
    check({tag, " R7 led"}, led_out, m_led);
  endtask

  task automatic idle(); step(0, 0, 8'h00, 8'h00, 0, 8'h00, "idle"); endtask
  task automatic rstat(input string t); step(1, 0, 8'h64, 8'h00, 0, 8'h00, t); endtask
  task automatic rdat(input string t); step(1, 0, 8'h60, 8'h00, 0, 8'h00, t); endtask
  task automatic wcmd(input logic [7:0] c, input string t); step(0, 1, 8'h64, c, 0, 8'h00, t); endtask
  task automatic wdat(input logic [7:0] d, input string t); step(0, 1, 8'h60, d, 0, 8'h00, t); endtask
  task automatic key(input logic [7:0] k, input string t); step(0, 0, 8'h00, 8'h00, 1, k, t); endtask

  initial begin
    #20000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rstat("R1 reset status");
    check("R1 reset status byte", bus_rdata, 8'h00);
    rdat("R1 reset data");
    key(8'h1C, "R6 key while disabled");
    rstat("R6 disabled ignore");
    check("R6 obf stays 0", bus_rdata & 1, 0);
    wdat(8'h07, "R7 data write no pending");
    rstat("R4 ibf after write");
    check("R4 ibf set", (bus_rdata >> 1) & 1, 1);
    rstat("R4 ibf one cycle");
    check("R7 no pending led", led_out, 0);
    wcmd(8'hAA, "R5 self test");
    rstat("R5 R2 status after test");
    check("R5 status", bus_rdata, 8'h0F);
    rdat("R5 R3 data read");
    check("R5 reply byte", bus_rdata, 8'h55);
    rstat("R3 obf cleared");
    check("R3 obf cleared", bus_rdata & 1, 0);
    wcmd(8'hAE, "R6 enable");
    key(8'h1C, "R8 key accepted");
    rstat("R8 status");
    check("R8 obf set", bus_rdata & 1, 1);
    key(8'h32, "R9 key while full");
    rstat("R9 timeout set");
    check("R9 timeout bit", (bus_rdata >> 6) & 1, 1);
    rstat("R9 timeout cleared");
    check("R9 timeout cleared", (bus_rdata >> 6) & 1, 0);
    rdat("R8 data read");
    check("R8 held scancode", bus_rdata, 8'h1C);
    wcmd(8'hED, "R7 set led cmd");
    wdat(8'hFD, "R7 led arg");
    idle();
    check("R7 led value", led_out, 3'h5);
    rdat("R7 ack read");
    check("R7 ack byte", bus_rdata, 8'hFA);
    wcmd(8'hED, "R10 set led cmd");
    wcmd(8'h20, "R10 unknown cancels");
    wdat(8'h02, "R10 data after cancel");
    idle();
    check("R10 led kept", led_out, 3'h5);
    rstat("R10 no reply");
    check("R10 obf 0", bus_rdata & 1, 0);
    key(8'h11, "R8 key");
    wcmd(8'hAA, "R10 reply overwrites");
    rdat("R10 overwritten data");
    check("R10 reply replaced key", bus_rdata, 8'h55);
    rstat("R9 clear");
    step(0, 1, 8'h64, 8'hAA, 1, 8'h22, "R9 key with reply");
    rstat("R9 drop on reply");
    check("R9 timeout on reply", (bus_rdata >> 6) & 1, 1);
    rdat("R9 data is reply");
    check("R9 reply kept", bus_rdata, 8'h55);
    wdat(8'h00, "R4 b2b 1");
    wcmd(8'h00, "R4 b2b 2");
    rstat("R4 R2 ibf after b2b");
    check("R2 last write was command", (bus_rdata >> 3) & 1, 1);
    for (int i = 0; i < 8; i++) key(8'h40 + i[7:0], "R9 burst");
    for (int i = 0; i < 4; i++) begin rstat("R2 poll"); rdat("R3 drain"); end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule